// File: doc/BRIEF.md
# Cell Header Edit Buffer with Byte Protect

This block holds the editable part of one received cell: four header bytes, a header check byte and up to four pre/post-pend bytes. A controller reads and rewrites these bytes through a 32-bit command port before the cell moves into storage. Each command carries a 4-bit lane mask. A write-protect bit per byte stops a put from altering chosen bytes. A separate clear operation zeroes chosen bytes, usually so that the transmit side can later OR new bits into them. The check byte can be written, but it is never returned by a read.

On the transmit side, a byte stream passes through a one-cycle register stage. The controller can arm an OR word with a command. That word is applied to the first four bytes of the next cell that starts, with lane i going to header byte i. When nothing is armed, the stream passes through unchanged. A command-port state machine (`CS_IDLE`, `CS_RESP`) returns read data. It moves from `CS_IDLE` to `CS_RESP` on a get, stays in `CS_RESP` while gets follow back to back, and returns to `CS_IDLE` otherwise. A stream state machine (`TS_IDLE`, `TS_HDR`, `TS_BODY`) follows the cell:

- Start of cell in any state goes to `TS_HDR`.
- `TS_HDR` moves to `TS_BODY` after header byte 3.
- An end-of-cell byte in `TS_HDR` or `TS_BODY` returns the machine to `TS_IDLE`.

Top module: `hedit_top`

## Requirements
- R1: After reset, the held header, pre/post-pend word and check byte are zero, all protect bits are clear, no OR word is armed, and `rd_valid` and `tx_out_valid` are low.
- R2: A cycle with `in_load` high copies `in_hdr`, `in_pp` and `in_crc` into the buffer at that edge. Any put, clear or check-byte write in the same cycle is dropped.
- R3: A get (`cmd_op`=1) drives `rd_valid` high in the next cycle. `rd_data` then holds the word selected by `cmd_sel` (0 = header, 1 = pre/post-pend), with lanes outside `cmd_mask` forced to zero. Lane i is bits 8i+7..8i.
- R4: A put (`cmd_op`=2) writes the `cmd_wdata` lanes that are set in `cmd_mask` into the selected word. Protected bytes are skipped.
- R5: Protect-set (`cmd_op`=4) and protect-clear (`cmd_op`=5) set or clear the protect bit of each masked lane of the selected word. Protect bits survive loads until they are cleared.
- R6: A clear (`cmd_op`=3) zeroes the masked lanes of the selected word even when they are protected. It leaves the protect bits unchanged.
- R7: A check-byte write (`cmd_op`=6) stores `cmd_wdata[7:0]`, which is visible on `buf_crc`. A get never returns the check byte.
- R8: An OR-edit write (`cmd_op`=7) arms the word `cmd_wdata` with unmasked lanes zeroed. At the next start of cell, lane i is ORed into stream byte i for i = 0..3.
- R9: An armed OR word is used by exactly one cell. Bytes after the fourth are never altered, and a cell that starts with nothing armed passes unchanged.
- R10: `tx_out_valid`, `tx_out_sof`, `tx_out_eof` and `tx_out_byte` follow the stream inputs with exactly one cycle of latency.
- R11: An OR-edit write in the same cycle as a start of cell does not affect that cell. It is armed for the following cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_load | input | 1 | Capture a new cell's editable bytes |
| in_hdr | input | 32 | Header bytes of the incoming cell |
| in_pp | input | 32 | Pre/post-pend bytes of the incoming cell |
| in_crc | input | 8 | Header check byte of the incoming cell |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | 1 | Word select: 0 header, 1 pre/post-pend |
| cmd_mask | input | 4 | Byte-lane mask |
| cmd_wdata | input | 32 | Command write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| buf_hdr | output | 32 | Held header bytes toward storage |
| buf_pp | output | 32 | Held pre/post-pend bytes toward storage |
| buf_crc | output | 8 | Held check byte toward storage |
| tx_in_valid | input | 1 | Stream byte present |
| tx_in_sof | input | 1 | First byte of a cell |
| tx_in_eof | input | 1 | Last byte of a cell |
| tx_in_byte | input | 8 | Stream byte from memory |
| tx_out_valid | output | 1 | Output byte present |
| tx_out_sof | output | 1 | Output first byte flag |
| tx_out_eof | output | 1 | Output last byte flag |
| tx_out_byte | output | 8 | Edited stream byte |

## Verification
The bench sets protect bits on some lanes and then issues full-mask puts. A design that ignored the protect mask would overwrite those lanes. A design that cleared protection on a load would lose it across a new cell. The bench clears a protected lane and then puts to it again, which exposes designs that let clear skip protected bytes or let clear drop their protect bits. It also writes an OR edit in the same cycle as a start of cell and streams two cells with an armed word. These patterns catch three faults: an edit leaking into the current cell, an edit applied to a second cell, and an edit reaching body bytes. A load that coincides with a put shows whether the put wrongly wins.

// File: rtl/hedit_pkg.sv
package hedit_pkg;

    // Command operation codes (match cmd_op encoding)
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_GET      = 3'd1,
        OP_PUT      = 3'd2,
        OP_CLEAR    = 3'd3,
        OP_PROT_SET = 3'd4,
        OP_PROT_CLR = 3'd5,
        OP_CRC_PUT  = 3'd6,
        OP_OR_EDIT  = 3'd7
    } hedit_op_e;

    // Command port states
    typedef enum logic [0:0] {
        CS_IDLE = 1'b0,
        CS_RESP = 1'b1
    } ctl_state_e;

    // Transmit stream states
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_HDR  = 2'd1,
        TS_BODY = 2'd2
    } tx_state_e;

endpackage

// File: rtl/hedit_ctrl.sv
module hedit_ctrl
    import hedit_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic                    cmd_sel,
    input  logic [LANES-1:0]        cmd_mask,
    input  logic [LANES*BYTE_W-1:0] cmd_wdata,
    input  logic                    in_load,
    input  logic [LANES*BYTE_W-1:0] hdr_word,
    input  logic [LANES*BYTE_W-1:0] pp_word,
    output logic [2*LANES-1:0]      put_be,
    output logic [2*LANES-1:0]      clr_be,
    output logic [2*LANES-1:0]      pset_be,
    output logic [2*LANES-1:0]      pclr_be,
    output logic                    crc_we,
    output logic                    edit_we,
    output logic [LANES*BYTE_W-1:0] edit_word,
    output logic                    rd_valid,
    output logic [LANES*BYTE_W-1:0] rd_data
);
    localparam int WORD_W = LANES * BYTE_W;

    hedit_op_e  op;
    ctl_state_e st_q, st_n;
    logic [2*LANES-1:0]  region_be;
    logic [WORD_W-1:0]   lane_bits;
    logic                is_get;
    logic                edits_ok;

    assign op = hedit_op_e'(cmd_op);

    // Lane mask widened to bit mask
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_bits[i*BYTE_W +: BYTE_W] = {BYTE_W{cmd_mask[i]}};
        end
    end

    // Place lane mask into header half or pre/post-pend half
    assign region_be = cmd_sel ? {cmd_mask, {LANES{1'b0}}}
                               : {{LANES{1'b0}}, cmd_mask};

    assign is_get   = cmd_valid && (op == OP_GET);
    assign edits_ok = cmd_valid && !in_load;

    // Decode of buffer-editing strobes
    always_comb begin
        put_be    = '0;
        clr_be    = '0;
        pset_be   = '0;
        pclr_be   = '0;
        crc_we    = 1'b0;
        edit_we   = 1'b0;
        edit_word = cmd_wdata & lane_bits;
        if (cmd_valid) begin
            unique case (op)
                OP_PUT:      if (edits_ok) put_be = region_be;
                OP_CLEAR:    if (edits_ok) clr_be = region_be;
                OP_PROT_SET: pset_be = region_be;
                OP_PROT_CLR: pclr_be = region_be;
                OP_CRC_PUT:  crc_we  = edits_ok;
                OP_OR_EDIT:  edit_we = 1'b1;
                default:     ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            CS_IDLE: st_n = is_get ? CS_RESP : CS_IDLE;
            CS_RESP: st_n = is_get ? CS_RESP : CS_IDLE;
            default: st_n = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_n;
    end

    // Output register: read word snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (is_get) begin
            rd_data <= (cmd_sel ? pp_word : hdr_word) & lane_bits;
        end
    end

    assign rd_valid = (st_q == CS_RESP);

endmodule

// File: rtl/hedit_store.sv
module hedit_store #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_load,
    input  logic [LANES*BYTE_W-1:0] in_hdr,
    input  logic [LANES*BYTE_W-1:0] in_pp,
    input  logic [BYTE_W-1:0]       in_crc,
    input  logic [2*LANES-1:0]      put_be,
    input  logic [2*LANES-1:0]      clr_be,
    input  logic [2*LANES-1:0]      pset_be,
    input  logic [2*LANES-1:0]      pclr_be,
    input  logic                    crc_we,
    input  logic [LANES*BYTE_W-1:0] wdata,
    output logic [LANES*BYTE_W-1:0] hdr_word,
    output logic [LANES*BYTE_W-1:0] pp_word,
    output logic [BYTE_W-1:0]       crc_byte,
    output logic [2*LANES-1:0]      prot
);
    localparam int NBYTES = 2 * LANES;
    localparam int WORD_W = LANES * BYTE_W;

    logic [2*WORD_W-1:0] load_all;
    logic [2*WORD_W-1:0] bytes_q;
    logic [NBYTES-1:0]   prot_q;
    logic [BYTE_W-1:0]   crc_q;

    assign load_all = {in_pp, in_hdr};

    // One byte cell and one protect flag per editable byte
    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        localparam int LANE = j % LANES;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[j*BYTE_W +: BYTE_W] <= '0;
            end else if (in_load) begin
                bytes_q[j*BYTE_W +: BYTE_W] <= load_all[j*BYTE_W +: BYTE_W];
            end else if (clr_be[j]) begin
                bytes_q[j*BYTE_W +: BYTE_W] <= '0;
            end else if (put_be[j] && !prot_q[j]) begin
                bytes_q[j*BYTE_W +: BYTE_W] <= wdata[LANE*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)          prot_q[j] <= 1'b0;
            else if (pset_be[j]) prot_q[j] <= 1'b1;
            else if (pclr_be[j]) prot_q[j] <= 1'b0;
        end
    end

    // Check byte: writable, never read back through the command port
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= '0;
        else if (in_load) crc_q <= in_crc;
        else if (crc_we)  crc_q <= wdata[BYTE_W-1:0];
    end

    assign hdr_word = bytes_q[WORD_W-1:0];
    assign pp_word  = bytes_q[2*WORD_W-1:WORD_W];
    assign crc_byte = crc_q;
    assign prot     = prot_q;

endmodule

// File: rtl/hedit_tx_or.sv
module hedit_tx_or
    import hedit_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    edit_we,
    input  logic [LANES*BYTE_W-1:0] edit_word,
    input  logic                    tx_in_valid,
    input  logic                    tx_in_sof,
    input  logic                    tx_in_eof,
    input  logic [BYTE_W-1:0]       tx_in_byte,
    output logic                    tx_out_valid,
    output logic                    tx_out_sof,
    output logic                    tx_out_eof,
    output logic [BYTE_W-1:0]       tx_out_byte,
    output logic                    pend
);
    localparam int WORD_W = LANES * BYTE_W;
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    tx_state_e         st_q, st_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [WORD_W-1:0] edit_q;
    logic [WORD_W-1:0] act_q;
    logic              pend_q;
    logic              take_sof;
    logic [BYTE_W-1:0] or_byte;

    assign take_sof = tx_in_valid && tx_in_sof;

    // OR value for the byte now on the input
    always_comb begin
        or_byte = '0;
        if (take_sof) begin
            or_byte = pend_q ? edit_q[BYTE_W-1:0] : '0;
        end else if (st_q == TS_HDR) begin
            or_byte = act_q[idx_q*BYTE_W +: BYTE_W];
        end
    end

    // Next-state logic
    always_comb begin
        st_n  = st_q;
        idx_n = idx_q;
        if (take_sof) begin
            st_n  = tx_in_eof ? TS_IDLE : ((LANES > 1) ? TS_HDR : TS_BODY);
            idx_n = IDX_W'(1);
        end else if (tx_in_valid) begin
            unique case (st_q)
                TS_IDLE: st_n = TS_IDLE;
                TS_HDR: begin
                    if (tx_in_eof) begin
                        st_n = TS_IDLE;
                    end else if (idx_q == LAST_IDX) begin
                        st_n = TS_BODY;
                    end else begin
                        idx_n = idx_q + IDX_W'(1);
                    end
                end
                TS_BODY: st_n = tx_in_eof ? TS_IDLE : TS_BODY;
                default: st_n = TS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TS_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_n;
            idx_q <= idx_n;
        end
    end

    // Armed edit word and per-cell snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edit_q <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (take_sof) act_q <= pend_q ? edit_q : '0;
            if (edit_we) begin
                edit_q <= edit_word;
                pend_q <= 1'b1;
            end else if (take_sof) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_out_valid <= 1'b0;
            tx_out_sof   <= 1'b0;
            tx_out_eof   <= 1'b0;
            tx_out_byte  <= '0;
        end else begin
            tx_out_valid <= tx_in_valid;
            tx_out_sof   <= tx_in_sof;
            tx_out_eof   <= tx_in_eof;
            tx_out_byte  <= tx_in_byte | or_byte;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/hedit_top.sv
module hedit_top #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_load,
    input  logic [LANES*BYTE_W-1:0] in_hdr,
    input  logic [LANES*BYTE_W-1:0] in_pp,
    input  logic [BYTE_W-1:0]       in_crc,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic                    cmd_sel,
    input  logic [LANES-1:0]        cmd_mask,
    input  logic [LANES*BYTE_W-1:0] cmd_wdata,
    output logic                    rd_valid,
    output logic [LANES*BYTE_W-1:0] rd_data,
    output logic [LANES*BYTE_W-1:0] buf_hdr,
    output logic [LANES*BYTE_W-1:0] buf_pp,
    output logic [BYTE_W-1:0]       buf_crc,
    input  logic                    tx_in_valid,
    input  logic                    tx_in_sof,
    input  logic                    tx_in_eof,
    input  logic [BYTE_W-1:0]       tx_in_byte,
    output logic                    tx_out_valid,
    output logic                    tx_out_sof,
    output logic                    tx_out_eof,
    output logic [BYTE_W-1:0]       tx_out_byte
);
    localparam int WORD_W = LANES * BYTE_W;

    logic [2*LANES-1:0] put_be, clr_be, pset_be, pclr_be;
    logic               crc_we, edit_we;
    logic [WORD_W-1:0]  edit_word;
    logic [2*LANES-1:0] prot_w;
    logic               pend_w;

    hedit_ctrl #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_sel   (cmd_sel),
        .cmd_mask  (cmd_mask),
        .cmd_wdata (cmd_wdata),
        .in_load   (in_load),
        .hdr_word  (buf_hdr),
        .pp_word   (buf_pp),
        .put_be    (put_be),
        .clr_be    (clr_be),
        .pset_be   (pset_be),
        .pclr_be   (pclr_be),
        .crc_we    (crc_we),
        .edit_we   (edit_we),
        .edit_word (edit_word),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    hedit_store #(.LANES(LANES), .BYTE_W(BYTE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_load  (in_load),
        .in_hdr   (in_hdr),
        .in_pp    (in_pp),
        .in_crc   (in_crc),
        .put_be   (put_be),
        .clr_be   (clr_be),
        .pset_be  (pset_be),
        .pclr_be  (pclr_be),
        .crc_we   (crc_we),
        .wdata    (cmd_wdata),
        .hdr_word (buf_hdr),
        .pp_word  (buf_pp),
        .crc_byte (buf_crc),
        .prot     (prot_w)
    );

    hedit_tx_or #(.LANES(LANES), .BYTE_W(BYTE_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .edit_we      (edit_we),
        .edit_word    (edit_word),
        .tx_in_valid  (tx_in_valid),
        .tx_in_sof    (tx_in_sof),
        .tx_in_eof    (tx_in_eof),
        .tx_in_byte   (tx_in_byte),
        .tx_out_valid (tx_out_valid),
        .tx_out_sof   (tx_out_sof),
        .tx_out_eof   (tx_out_eof),
        .tx_out_byte  (tx_out_byte),
        .pend         (pend_w)
    );

endmodule

// File: rtl/hedit_checker.sv
module hedit_checker #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_load,
    input logic [LANES*BYTE_W-1:0] in_hdr,
    input logic [LANES*BYTE_W-1:0] in_pp,
    input logic                    cmd_valid,
    input logic [2:0]              cmd_op,
    input logic                    cmd_sel,
    input logic [LANES-1:0]        cmd_mask,
    input logic                    rd_valid,
    input logic [LANES*BYTE_W-1:0] buf_hdr,
    input logic                    tx_in_valid,
    input logic                    tx_in_sof,
    input logic [BYTE_W-1:0]       tx_in_byte,
    input logic                    tx_out_valid,
    input logic [BYTE_W-1:0]       tx_out_byte,
    input logic [2*LANES-1:0]      prot,
    input logic                    pend
);
    localparam int WORD_W = LANES * BYTE_W;

    function automatic logic [WORD_W-1:0] widen(input logic [LANES-1:0] m);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*BYTE_W +: BYTE_W] = {BYTE_W{m[i]}};
        return r;
    endfunction

    logic hdr_put, hdr_clr, or_write;
    assign hdr_put  = cmd_valid && (cmd_op == 3'd2) && !cmd_sel && !in_load;
    assign hdr_clr  = cmd_valid && (cmd_op == 3'd3) && !cmd_sel && !in_load;
    assign or_write = cmd_valid && (cmd_op == 3'd7);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |=> (buf_hdr == $past(in_hdr)));

    assert_get_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && (cmd_op == 3'd1)));

    assert_protect_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_put |=> ((buf_hdr & widen(prot[LANES-1:0]))
                     == $past(buf_hdr & widen(prot[LANES-1:0]))));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_clr |=> ((buf_hdr & $past(widen(cmd_mask))) == '0));

    assert_edit_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_sof && !or_write) |=> !pend);

    assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_sof && !pend) |=> (tx_out_byte == $past(tx_in_byte)));

    assert_tx_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid == $past(tx_in_valid));

endmodule

bind hedit_top hedit_checker #(.LANES(LANES), .BYTE_W(BYTE_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_load      (in_load),
    .in_hdr       (in_hdr),
    .in_pp        (in_pp),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_sel      (cmd_sel),
    .cmd_mask     (cmd_mask),
    .rd_valid     (rd_valid),
    .buf_hdr      (buf_hdr),
    .tx_in_valid  (tx_in_valid),
    .tx_in_sof    (tx_in_sof),
    .tx_in_byte   (tx_in_byte),
    .tx_out_valid (tx_out_valid),
    .tx_out_byte  (tx_out_byte),
    .prot         (prot_w),
    .pend         (pend_w)
);

// File: tb/test_hedit_top.sv
module test_hedit_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_load = 1'b0;
    logic [31:0] in_hdr = '0, in_pp = '0;
    logic [7:0]  in_crc = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_sel = 1'b0;
    logic [3:0]  cmd_mask = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data, buf_hdr, buf_pp;
    logic [7:0]  buf_crc;
    logic        tx_in_valid = 1'b0, tx_in_sof = 1'b0, tx_in_eof = 1'b0;
    logic [7:0]  tx_in_byte = '0;
    logic        tx_out_valid, tx_out_sof, tx_out_eof;
    logic [7:0]  tx_out_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hedit_top i_hedit_top (
        .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_hdr(in_hdr),
        .in_pp(in_pp), .in_crc(in_crc), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_mask(cmd_mask),
        .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .buf_hdr(buf_hdr), .buf_pp(buf_pp), .buf_crc(buf_crc),
        .tx_in_valid(tx_in_valid), .tx_in_sof(tx_in_sof),
        .tx_in_eof(tx_in_eof), .tx_in_byte(tx_in_byte),
        .tx_out_valid(tx_out_valid), .tx_out_sof(tx_out_sof),
        .tx_out_eof(tx_out_eof), .tx_out_byte(tx_out_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One command cycle; returns at the negedge after the capturing edge
    task automatic issue(input logic [2:0] op, input logic sel,
                         input logic [3:0] mask, input logic [31:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_mask = mask; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic load(input logic [31:0] h, input logic [31:0] p, input logic [7:0] c);
        @(negedge clk);
        in_load = 1'b1; in_hdr = h; in_pp = p; in_crc = c;
        @(negedge clk);
        in_load = 1'b0;
    endtask

    // Stream n bytes; optional OR-edit command on the first byte's cycle
    task automatic stream(input string req, input int n,
                          input logic [7:0] b [8], input logic [7:0] e [8],
                          input bit edit_now, input logic [31:0] edit_wd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R10 valid", {31'd0, tx_out_valid}, 32'd1);
                check(req, {24'd0, tx_out_byte}, {24'd0, e[i-1]});
            end
            tx_in_valid = 1'b1; tx_in_byte = b[i];
            tx_in_sof = (i == 0); tx_in_eof = (i == n - 1);
            if (i == 0 && edit_now) begin
                cmd_valid = 1'b1; cmd_op = 3'd7; cmd_mask = 4'hF; cmd_wdata = edit_wd;
            end else begin
                cmd_valid = 1'b0; cmd_op = '0;
            end
        end
        @(negedge clk);
        check("R10 valid", {31'd0, tx_out_valid}, 32'd1);
        check(req, {24'd0, tx_out_byte}, {24'd0, e[n-1]});
        check("R10 eof", {31'd0, tx_out_eof}, 32'd1);
        tx_in_valid = 1'b0; tx_in_sof = 1'b0; tx_in_eof = 1'b0;
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R10 idle", {31'd0, tx_out_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 hdr", buf_hdr, 32'h0);
        check("R1 pp", buf_pp, 32'h0);
        check("R1 crc", {24'd0, buf_crc}, 32'h0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 tx_valid", {31'd0, tx_out_valid}, 32'd0);
    endtask

    task automatic t_load_get();
        load(32'h11223344, 32'hA0B0C0D0, 8'h5A);
        check("R2 hdr", buf_hdr, 32'h11223344);
        check("R2 pp", buf_pp, 32'hA0B0C0D0);
        check("R2 crc", {24'd0, buf_crc}, 32'h5A);
        issue(3'd1, 1'b0, 4'hF, 32'h0);
        check("R3 rd_valid", {31'd0, rd_valid}, 32'd1);
        check("R3 hdr word", rd_data, 32'h11223344);
        issue(3'd1, 1'b1, 4'h5, 32'h0);
        check("R3 masked pp", rd_data, 32'h00B000D0);
        @(negedge clk);
        check("R3 rd_valid drop", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_put_protect();
        issue(3'd4, 1'b0, 4'h3, 32'h0);
        issue(3'd2, 1'b0, 4'hF, 32'hDEADBEEF);
        check("R4 protected put", buf_hdr, 32'hDEAD3344);
        issue(3'd2, 1'b1, 4'h2, 32'h99887766);
        check("R4 masked put", buf_pp, 32'hA0B077D0);
        load(32'h01020304, 32'h0, 8'h0);
        issue(3'd2, 1'b0, 4'hF, 32'hFFFFFFFF);
        check("R5 protect across load", buf_hdr, 32'hFFFF0304);
        issue(3'd5, 1'b0, 4'h1, 32'h0);
        issue(3'd2, 1'b0, 4'hF, 32'hAAAAAAAA);
        check("R5 partial unprotect", buf_hdr, 32'hAAAA03AA);
        issue(3'd5, 1'b0, 4'hF, 32'h0);
    endtask

    task automatic t_clear();
        issue(3'd4, 1'b0, 4'h4, 32'h0);
        issue(3'd3, 1'b0, 4'h6, 32'h0);
        check("R6 clear over protect", buf_hdr, 32'hAA0000AA);
        issue(3'd2, 1'b0, 4'hF, 32'h55555555);
        check("R6 protect kept", buf_hdr, 32'h55005555);
        issue(3'd5, 1'b0, 4'hF, 32'h0);
    endtask

    task automatic t_crc();
        issue(3'd6, 1'b0, 4'hF, 32'h000000C3);
        check("R7 crc write", {24'd0, buf_crc}, 32'hC3);
        issue(3'd1, 1'b0, 4'hF, 32'h0);
        check("R7 get excludes crc", rd_data, 32'h55005555);
    endtask

    task automatic t_load_prio();
        @(negedge clk);
        in_load = 1'b1; in_hdr = 32'h0A0B0C0D; in_pp = '0; in_crc = '0;
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_sel = 1'b0; cmd_mask = 4'hF;
        cmd_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        in_load = 1'b0; cmd_valid = 1'b0;
        check("R2 load beats put", buf_hdr, 32'h0A0B0C0D);
    endtask

    task automatic t_out_edit();
        logic [7:0] b [8] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h0, 8'h0};
        logic [7:0] e [8] = '{8'h1F, 8'h20, 8'h3F, 8'h40, 8'h50, 8'h60, 8'h0, 8'h0};
        issue(3'd7, 1'b0, 4'h5, 32'h0F0F0F0F);
        stream("R8 or into header", 6, b, e, 1'b0, 32'h0);
        stream("R9 consumed once", 6, b, b, 1'b0, 32'h0);
    endtask

    task automatic t_body();
        logic [7:0] b [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        logic [7:0] e [8] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h04, 8'h05, 8'h06, 8'h07};
        issue(3'd7, 1'b0, 4'hF, 32'hFFFFFFFF);
        stream("R9 body untouched", 8, b, e, 1'b0, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] b [8] = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h0, 8'h0, 8'h0};
        logic [7:0] e [8] = '{8'h81, 8'h81, 8'h81, 8'h81, 8'h80, 8'h0, 8'h0, 8'h0};
        stream("R11 not this cell", 5, b, b, 1'b1, 32'h01010101);
        stream("R11 next cell", 5, b, e, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_get();
        t_put_protect();
        t_clear();
        t_crc();
        t_load_prio();
        t_out_edit();
        t_body();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule